// File: doc/BRIEF.md
# Alignment Fault Checker

This block sits at the address-generation stage of a load/store pipeline. For each request it decides whether the access must raise an alignment fault, whether it may go to memory with a misaligned address, and which low address bits memory should see. The decision depends on two mode bits: unaligned-enable (U) and strict-check (A). It also depends on the access class, on the memory type tag, and on two translation-control bits: translation enabled and extended page format. Some classes are checked for word alignment whatever the mode bits say.

All results are registered and appear one clock after the request. When an access faults, the memory request is suppressed in that cycle and a single constant fault status code is reported. Address translation and entry into the abort handler are left to the surrounding pipeline.

Top module: `align_fault_chk`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `fault`, `fault_code`, `mem_req`, `unal_ok` and `addr_out` are all 0.
- R2: Every output reflects the request sampled at the previous rising edge. A cycle with `req_valid` low yields all outputs 0.
- R3: With U=0 and A=1, the following accesses fault: a halfword (class 1) with address bit 0 set, a word (class 2) with bits [1:0] not 00, and a doubleword (class 3) with bits [2:0] not 000.
- R4: With U=0 and A=0, halfword, word and doubleword accesses never fault. `addr_out` is forced to the access size by clearing 1, 2 or 3 low bits respectively.
- R5: With U=1 and A=0, halfword and word accesses proceed at their own address. A doubleword faults unless bits [1:0] are 00.
- R6: With U=1 and A=1, a halfword faults when bit 0 is 1, a word faults when bits [1:0] are not 00, and a doubleword faults when bits [1:0] are not 00.
- R7: Multiple (class 4), swap/synchronization (class 5) and coprocessor (class 6) accesses fault whenever bits [1:0] are not 00, in every mode.
- R8: A load to the program counter (class 7) faults whenever bits [1:0] are not 00, in every mode.
- R9: With U=1 and A=0, a misaligned halfword or word to device (`mem_kind`=1) or strongly ordered (`mem_kind`=2) memory faults when `mmu_on` and `xpage` are both 1. Normal memory is `mem_kind`=0.
- R10: A byte access (class 0) never faults, and its address is passed through unchanged.
- R11: A faulting request drives `fault_code` to the parameter FAULT_CODE and holds `mem_req` low. A non-faulting valid request drives `mem_req` high and `fault_code` to 0. `addr_out` is 0 whenever `mem_req` is 0.
- R12: `unal_ok` is 1 only for a non-faulting, misaligned halfword or word request issued with U=1 and A=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| unal_en | input | 1 | Mode bit U: unaligned halfword/word enable |
| strict_en | input | 1 | Mode bit A: strict alignment check |
| mmu_on | input | 1 | Translation enabled |
| xpage | input | 1 | Extended page format selected |
| mem_kind | input | 2 | 0 normal, 1 device, 2 strongly ordered |
| acc_class | input | 3 | Access class code 0..7 |
| addr_lo | input | ADDR_LO_W | Low address bits |
| fault | output | 1 | Registered alignment fault |
| fault_code | output | FSC_W | Fault status code, 0 when no fault |
| mem_req | output | 1 | Memory request issued |
| unal_ok | output | 1 | Request proceeds misaligned |
| addr_out | output | ADDR_LO_W | Low address presented to memory |

## Verification
The bench sweeps every combination of mode bits, control bits, memory type, class and 3-bit offset, and compares each result with an arithmetic model built on address modulo access size. It targets three kinds of fault. A doubleword under U=1 that is checked against 8-byte alignment would raise a spurious fault at offset 4. A multiple or swap access left unchecked in the legacy mode would reach memory silently misaligned. A device-memory rule applied without both control bits would fault normal traffic. It also confirms that legacy-mode addresses are truncated and not passed through, which catches a design that issues misaligned accesses the memory side does not expect.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [2:0] {
    AC_BYTE   = 3'd0,
    AC_HALF   = 3'd1,
    AC_WORD   = 3'd2,
    AC_DWORD  = 3'd3,
    AC_MULTI  = 3'd4,
    AC_SYNC   = 3'd5,
    AC_COPROC = 3'd6,
    AC_PCLOAD = 3'd7
  } acc_class_e;

  typedef enum logic [1:0] {
    MK_NORMAL = 2'd0,
    MK_DEVICE = 2'd1,
    MK_STRONG = 2'd2
  } mem_kind_e;

  typedef struct packed {
    logic half_mis;
    logic word_mis;
    logic dword_mis;
  } mis_t;
endpackage

// File: rtl/misalign_decode.sv
module misalign_decode
  import align_pkg::*;
#(
  parameter int ADDR_LO_W = 3
) (
  input  logic [ADDR_LO_W-1:0] addr_lo,
  output mis_t                 mis
);
  localparam int DW_BITS = (ADDR_LO_W < 3) ? ADDR_LO_W : 3;

  always_comb begin
    mis.half_mis  = addr_lo[0];
    mis.word_mis  = |addr_lo[1:0];
    mis.dword_mis = |addr_lo[DW_BITS-1:0];
  end
endmodule

// File: rtl/align_rules.sv
module align_rules
  import align_pkg::*;
(
  input  logic       unal_en,
  input  logic       strict_en,
  input  logic       mmu_on,
  input  logic       xpage,
  input  mem_kind_e  mem_kind,
  input  acc_class_e acc_class,
  input  mis_t       mis,
  output logic       fault,
  output logic       unal_ok,
  output logic [1:0] clr_bits
);
  logic dev_chk;
  logic size_mis;

  always_comb begin
    dev_chk  = mmu_on && xpage && (mem_kind != MK_NORMAL);
    size_mis = (acc_class == AC_HALF) ? mis.half_mis : mis.word_mis;
    fault    = 1'b0;
    unal_ok  = 1'b0;
    clr_bits = 2'd0;
    case (acc_class)
      AC_BYTE: ;
      AC_HALF, AC_WORD: begin
        if (strict_en)
          fault = size_mis;
        else if (unal_en) begin
          if (size_mis && dev_chk) fault = 1'b1;
          else                     unal_ok = size_mis;
        end else
          clr_bits = (acc_class == AC_HALF) ? 2'd1 : 2'd2;
      end
      AC_DWORD: begin
        if (unal_en)        fault = mis.word_mis;
        else if (strict_en) fault = mis.dword_mis;
        else                clr_bits = 2'd3;
      end
      default: fault = mis.word_mis;
    endcase
  end
endmodule

// File: rtl/align_fault_chk.sv
module align_fault_chk
  import align_pkg::*;
#(
  parameter int              ADDR_LO_W  = 3,
  parameter int              FSC_W      = 5,
  parameter logic [FSC_W-1:0] FAULT_CODE = 5'b00001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 unal_en,
  input  logic                 strict_en,
  input  logic                 mmu_on,
  input  logic                 xpage,
  input  logic [1:0]           mem_kind,
  input  logic [2:0]           acc_class,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  output logic                 fault,
  output logic [FSC_W-1:0]     fault_code,
  output logic                 mem_req,
  output logic                 unal_ok,
  output logic [ADDR_LO_W-1:0] addr_out
);
  localparam logic [ADDR_LO_W-1:0] ONE = ADDR_LO_W'(1);

  mis_t                 mis;
  logic                 fault_c;
  logic                 unal_c;
  logic [1:0]           clr_c;
  logic [ADDR_LO_W-1:0] keep_mask;

  misalign_decode #(.ADDR_LO_W(ADDR_LO_W)) u_dec (
    .addr_lo (addr_lo),
    .mis     (mis)
  );

  align_rules u_rules (
    .unal_en   (unal_en),
    .strict_en (strict_en),
    .mmu_on    (mmu_on),
    .xpage     (xpage),
    .mem_kind  (mem_kind_e'(mem_kind)),
    .acc_class (acc_class_e'(acc_class)),
    .mis       (mis),
    .fault     (fault_c),
    .unal_ok   (unal_c),
    .clr_bits  (clr_c)
  );

  assign keep_mask = ~((ONE << clr_c) - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault      <= 1'b0;
      fault_code <= '0;
      mem_req    <= 1'b0;
      unal_ok    <= 1'b0;
      addr_out   <= '0;
    end else begin
      fault      <= req_valid && fault_c;
      fault_code <= (req_valid && fault_c) ? FAULT_CODE : '0;
      mem_req    <= req_valid && !fault_c;
      unal_ok    <= req_valid && !fault_c && unal_c;
      addr_out   <= (req_valid && !fault_c) ? (addr_lo & keep_mask) : '0;
    end
  end

  a_r11_fault_blocks_req: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_req && fault_code == FAULT_CODE));
  a_r10_byte_never_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && acc_class == 3'd0) |=> (!fault && mem_req));
  a_r7_block_class_checked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && acc_class >= 3'd4 && acc_class <= 3'd6 && addr_lo[1:0] != 2'b00) |=> fault);
  a_r8_pc_load_checked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && acc_class == 3'd7 && addr_lo[1:0] != 2'b00) |=> fault);
  a_r12_unal_needs_mode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(unal_en && !strict_en)) |=> !unal_ok);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fault && !mem_req && !unal_ok));
  a_r4_legacy_no_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !unal_en && !strict_en && acc_class >= 3'd1 && acc_class <= 3'd3) |=> mem_req);
endmodule

// File: tb/align_fault_chk_test.sv
module align_fault_chk_test;
  localparam int AW = 3;
  localparam int FW = 5;
  localparam logic [FW-1:0] CODE = 5'b00001;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, unal_en, strict_en, mmu_on, xpage;
  logic [1:0] mem_kind;
  logic [2:0] acc_class;
  logic [AW-1:0] addr_lo;
  logic fault, mem_req, unal_ok;
  logic [FW-1:0] fault_code;
  logic [AW-1:0] addr_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  align_fault_chk #(.ADDR_LO_W(AW), .FSC_W(FW), .FAULT_CODE(CODE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .unal_en(unal_en),
    .strict_en(strict_en), .mmu_on(mmu_on), .xpage(xpage), .mem_kind(mem_kind),
    .acc_class(acc_class), .addr_lo(addr_lo), .fault(fault),
    .fault_code(fault_code), .mem_req(mem_req), .unal_ok(unal_ok), .addr_out(addr_out)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int size_of(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 4;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 1; unal_en = 1; strict_en = 0; mmu_on = 0; xpage = 0;
    mem_kind = 0; acc_class = 3'd2; addr_lo = 3'd1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1", "fault", int'(fault), 0);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "unal_ok", int'(unal_ok), 0);
    chk("R1", "addr_out", int'(addr_out), 0);
    rst = 0; req_valid = 0;
    @(negedge clk);
    // R2: idle cycle yields quiet outputs
    chk("R2", "fault", int'(fault), 0);
    chk("R2", "mem_req", int'(mem_req), 0);
    chk("R2", "code", int'(fault_code), 0);

    for (int u = 0; u < 2; u++)
      for (int a = 0; a < 2; a++)
        for (int mx = 0; mx < 4; mx++)
          for (int k = 0; k < 3; k++)
            for (int c = 0; c < 8; c++)
              for (int ad = 0; ad < 8; ad++) begin
                int sz, off, ef, eu, ea;
                bit mis, devq;
                string tag;
                sz = size_of(c);
                off = ad % sz;
                mis = (off != 0);
                devq = (mx == 3) && (k != 0);
                ef = 0;
                tag = "R3";
                if (c == 0) tag = "R10";
                else if (c == 7) begin ef = mis; tag = "R8"; end
                else if (c >= 4) begin ef = mis; tag = "R7"; end
                else if (c == 3) begin
                  if (u == 1) ef = ((ad % 4) != 0);
                  else if (a == 1) ef = mis;
                  tag = (u == 1) ? ((a == 1) ? "R6" : "R5") : ((a == 1) ? "R3" : "R4");
                end else begin
                  if (a == 1) ef = mis;
                  else if (u == 1) ef = (mis && devq) ? 1 : 0;
                  tag = (u == 1) ? ((a == 1) ? "R6" : (devq ? "R9" : "R5")) : ((a == 1) ? "R3" : "R4");
                end
                eu = (u == 1 && a == 0 && (c == 1 || c == 2) && mis && !devq) ? 1 : 0;
                if (ef != 0) ea = 0;
                else if (u == 0 && a == 0 && c >= 1 && c <= 3) ea = ad - off;
                else ea = ad;

                req_valid = 1; unal_en = u[0]; strict_en = a[0];
                mmu_on = mx[0]; xpage = mx[1]; mem_kind = k[1:0];
                acc_class = c[2:0]; addr_lo = ad[2:0];
                @(negedge clk);
                chk(tag, "fault", int'(fault), ef);
                chk("R11", "mem_req", int'(mem_req), (ef != 0) ? 0 : 1);
                chk("R11", "fault_code", int'(fault_code), (ef != 0) ? int'(CODE) : 0);
                chk("R12", "unal_ok", int'(unal_ok), eu);
                chk((c == 0) ? "R10" : "R4", "addr_out", int'(addr_out), ea);
              end

    req_valid = 0;
    @(negedge clk);
    chk("R2", "mem_req after idle", int'(mem_req), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule